// File: doc/BRIEF.md
# Timer Input Capture Unit

This block stores a snapshot of a free-running timer count whenever a qualified level change arrives on an external capture pin. The pin is asynchronous to the system clock. It first passes through a two-flop synchronizer. An optional agreement filter follows, which rejects pulses shorter than four clock cycles. After that comes an edge detector that fires on rising or falling transitions, as configured.

Each capture loads the count into the capture register and sets a sticky flag. The flag can raise an interrupt request. Software clears the flag by writing a one to it, and an interrupt acknowledge also clears it.

The capture register has a low half and a high half. The high half shares storage with a compare register. In narrow mode only the low half is captured, and the shared register acts as a plain compare value against the counter's low half. In wide mode that register receives the high half of the count, and its compare output is switched off. The counter itself comes in as an input.

Top module: `capt_top`

## Requirements
- R1: With `edge_rise_i`=1 a low-to-high transition of the conditioned pin triggers a capture; with `edge_rise_i`=0 a high-to-low transition does. A transition in the other direction triggers nothing.
- R2: A capture loads `count_i` into the capture register. The low half appears on `cap_value_o[7:0]`.
- R3: The flag `flag_o` rises at the same clock edge that loads the capture register. It stays set until it is cleared. If a clear request and a capture coincide, the flag ends up set.
- R4: `irq_o` is high exactly when `flag_o` is high and `irq_en_i` is 1.
- R5: A one on `flag_w1c_i` or on `irq_ack_i` at a clock edge clears the flag, unless a capture happens at that edge.
- R6: With `filt_en_i`=1, the conditioned level changes only after four consecutive synchronized samples agree. A pin pulse of three cycles or fewer causes no capture, and a pulse of four cycles causes one.
- R7: Suppose the pin changes before clock edge n. With the filter off, the capture register and flag update at edge n+2. With the filter on, they update at edge n+6. In both cases the stored count is the value `count_i` held just before that edge.
- R8: A new capture overwrites the register even when the previous value was never read.
- R9: With `wide_i`=0, `cap_value_o[15:8]` reads 0. In this mode `cmp_wr_i` loads `cmp_wdata_i` into the shared register, and `cmp_match_o` is high when `count_i[7:0]` equals that register. With `wide_i`=1, a capture loads `count_i[15:8]` into the shared register, `cap_value_o[15:8]` shows that register, and `cmp_match_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| count_i | input | 16 | Free-running timer count |
| edge_rise_i | input | 1 | 1 = rising edge captures, 0 = falling edge captures |
| filt_en_i | input | 1 | Enables the four-sample agreement filter |
| irq_en_i | input | 1 | Interrupt enable |
| wide_i | input | 1 | 1 = 16-bit capture, 0 = 8-bit capture |
| flag_w1c_i | input | 1 | Write-one-to-clear strobe for the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge; clears the flag |
| cmp_wr_i | input | 1 | Write strobe for the shared high/compare register |
| cmp_wdata_i | input | 8 | Data for the shared register |
| cap_value_o | output | 16 | Capture readback |
| cmp_hi_o | output | 8 | Contents of the shared register |
| cmp_match_o | output | 1 | Compare match in narrow mode |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the pin on a falling clock edge, just before rising edge n. With the filter off, it expects the flag and the register to be unchanged after edges n and n+1, and updated after edge n+2 with the count from before that edge. With the filter on, the same check moves to edge n+6. All samples are taken at falling edges, so every registered result is read half a cycle after it settles. The interrupt and compare outputs are combinational, and the bench checks them in the same half cycle as the inputs that drive them.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/capt_sync.sv
module capt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/capt_filter.sv
module capt_filter #(
  parameter int TAPS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic dout_o
);
  localparam int HIST = TAPS - 1;

  logic [HIST-1:0] hist_q, hist_d;
  logic            out_q, out_d, agree;

  // The live sample plus HIST stored samples form the agreement window.
  always_comb begin
    hist_d = {hist_q[HIST-2:0], din_i};
    agree  = (hist_q == {HIST{din_i}});
    out_d  = agree ? din_i : out_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign dout_o = out_q;

  // R6: a change of the filtered level matches the sample that was live
  p_filt_agree_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_q != $past(out_q)) |-> (out_q == $past(din_i)));
endmodule

// File: rtl/capt_edge.sv
module capt_edge
  import capt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  edge_sel_e sel_i,
  output logic      hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    unique case (sel_i)
      EDGE_RISE: hit_o = lvl_i & ~prev_q;
      default:   hit_o = ~lvl_i & prev_q;
    endcase
  end

  // R1: a level transition yields a single-cycle hit
  p_single_hit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/capt_top.sv
module capt_top
  import capt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_pin_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               edge_rise_i,
  input  logic               filt_en_i,
  input  logic               irq_en_i,
  input  logic               wide_i,
  input  logic               flag_w1c_i,
  input  logic               irq_ack_i,
  input  logic               cmp_wr_i,
  input  logic [CNT_W/2-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0]   cap_value_o,
  output logic [CNT_W/2-1:0] cmp_hi_o,
  output logic               cmp_match_o,
  output logic               flag_o,
  output logic               irq_o
);
  localparam int HALF = CNT_W / 2;

  logic pin_sync, pin_filt, pin_lvl, cap_hit;

  capt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(cap_pin_i), .q_o(pin_sync));

  capt_filter #(.TAPS(FILT_TAPS)) u_filt (
    .clk_i (clk_i), .rst_ni(rst_ni), .din_i(pin_sync), .dout_o(pin_filt));

  assign pin_lvl = filt_en_i ? pin_filt : pin_sync;

  capt_edge u_edge (
    .clk_i (clk_i), .rst_ni(rst_ni), .lvl_i(pin_lvl),
    .sel_i (edge_sel_e'(edge_rise_i)), .hit_o(cap_hit));

  logic [HALF-1:0] lo_q, lo_d, hi_q, hi_d;
  logic            lo_en, hi_en, flag_q, flag_d, flag_en;

  always_comb begin
    lo_en   = cap_hit;
    lo_d    = count_i[HALF-1:0];
    hi_en   = (cap_hit && wide_i) || cmp_wr_i;
    hi_d    = (cap_hit && wide_i) ? count_i[CNT_W-1:HALF] : cmp_wdata_i;
    flag_en = cap_hit || flag_w1c_i || irq_ack_i;
    flag_d  = cap_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (lo_en)   lo_q   <= lo_d;
      if (hi_en)   hi_q   <= hi_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign cap_value_o = {(wide_i ? hi_q : {HALF{1'b0}}), lo_q};
  assign cmp_hi_o    = hi_q;
  assign cmp_match_o = !wide_i && (count_i[HALF-1:0] == hi_q);
  assign flag_o      = flag_q;
  assign irq_o       = flag_q && irq_en_i;

  // R2: the low half holds the count seen at the capture edge
  p_cap_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> (lo_q == $past(count_i[HALF-1:0])));

  // R3: capture always leaves the flag set, even against a clear
  p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> flag_q);

  // R3: without a clear request the flag is sticky
  p_flag_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_w1c_i && !irq_ack_i) |=> flag_q);

  // R5: the flag only drops after a clear request
  p_flag_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(flag_w1c_i || irq_ack_i));

  // R9: shared register is untouched without a write or a wide capture
  p_hi_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_wr_i && !(cap_hit && wide_i)) |=> (hi_q == $past(hi_q)));
endmodule

// File: tb/test_capt_top.sv
module test_capt_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pin, rise, filt, irq_en, wide, w1c, ack, cmp_wr;
  logic [7:0]  cmp_wdata;
  logic [15:0] tcnt;
  logic [15:0] cap_value;
  logic [7:0]  cmp_hi;
  logic        cmp_match, flag, irq;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt <= 16'hA5F0;
    else        tcnt <= tcnt + 16'd1;
  end

  capt_top i_capt_top (
    .clk_i(clk), .rst_ni(rst_n), .cap_pin_i(pin), .count_i(tcnt),
    .edge_rise_i(rise), .filt_en_i(filt), .irq_en_i(irq_en), .wide_i(wide),
    .flag_w1c_i(w1c), .irq_ack_i(ack), .cmp_wr_i(cmp_wr), .cmp_wdata_i(cmp_wdata),
    .cap_value_o(cap_value), .cmp_hi_o(cmp_hi), .cmp_match_o(cmp_match),
    .flag_o(flag), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    w1c = 1'b1; ticks(1); w1c = 1'b0;
  endtask

  task automatic settle(input logic lvl);
    pin = lvl; ticks(10); clear_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] t0, expv;
    int lat, bad;
    rst_n = 1'b0; pin = 0; rise = 1; filt = 0; irq_en = 0; wide = 0;
    w1c = 0; ack = 0; cmp_wr = 0; cmp_wdata = 8'h00;
    ticks(3);
    rst_n = 1'b1;
    ticks(2);
    check("R3 reset flag", flag, 0);
    check("R4 reset irq", irq, 0);
    check("R2 reset value", cap_value, 0);
    check("R9 reset shared reg", cmp_hi, 0);

    // Sweep filter, edge direction and width
    for (int f = 0; f < 2; f++) begin
      for (int r = 0; r < 2; r++) begin
        for (int w = 0; w < 2; w++) begin
          filt = f[0]; rise = r[0]; wide = w[0];
          lat = f ? 6 : 2;
          settle(!r[0]);
          check("R5 cleared before edge", flag, 0);
          t0 = tcnt;
          pin = r[0];
          ticks(lat);
          check("R7 no update before due edge", flag, 0);
          ticks(1);
          check("R3 flag with capture", flag, 1);
          expv = t0 + 16'(lat);
          if (!w) expv[15:8] = 8'h00;
          check("R7 captured count", cap_value, expv);
          clear_flag();
          pin = !r[0];
          ticks(10);
          check("R1 opposite edge ignored", flag, 0);
        end
      end
    end

    // R8 overwrite without reading
    filt = 0; rise = 1; wide = 1;
    settle(0);
    pin = 1; ticks(3);
    pin = 0; ticks(3);
    t0 = tcnt; pin = 1; ticks(3);
    check("R8 second capture overwrites", cap_value, t0 + 16'd2);

    // R3 clear and capture at the same edge
    pin = 0; ticks(5);
    check("R3 flag still set", flag, 1);
    t0 = tcnt; pin = 1; ticks(2);
    w1c = 1; ticks(1); w1c = 0;
    check("R3 capture beats clear", flag, 1);
    check("R3 value at coincident clear", cap_value, t0 + 16'd2);
    clear_flag();
    check("R5 write-one clears", flag, 0);

    // R6 glitch rejection and four-sample boundary
    settle(0);
    filt = 1;
    pin = 1; ticks(3); pin = 0; ticks(12);
    check("R6 three-cycle pulse rejected", flag, 0);
    t0 = tcnt; pin = 1; ticks(4); pin = 0; ticks(3);
    check("R6 four-cycle pulse accepted", flag, 1);
    check("R6 four-cycle pulse value", cap_value, t0 + 16'd6);
    ticks(10); clear_flag();
    filt = 0;
    t0 = tcnt; pin = 1; ticks(1); pin = 0; ticks(2);
    check("R6 one-cycle pulse passes unfiltered", flag, 1);
    check("R7 unfiltered pulse value", cap_value, t0 + 16'd2);

    // R4 interrupt gating and R5 acknowledge
    irq_en = 1; #1;
    check("R4 irq with enable", irq, 1);
    irq_en = 0; #1;
    check("R4 irq masked", irq, 0);
    irq_en = 1;
    ticks(1);
    ack = 1; ticks(1); ack = 0; #1;
    check("R5 ack clears flag", flag, 0);
    check("R4 irq drops with flag", irq, 0);
    irq_en = 0;

    // R9 narrow mode compare and readback
    ticks(5);
    wide = 0; cmp_wdata = 8'h37; cmp_wr = 1; ticks(1); cmp_wr = 0;
    check("R9 shared reg written", cmp_hi, 8'h37);
    bad = 0;
    for (int i = 0; i < 300; i++) begin
      if (cmp_match !== (tcnt[7:0] == 8'h37)) bad++;
      ticks(1);
    end
    check("R9 narrow compare tracks count", bad, 0);
    check("R9 narrow high byte reads zero", cap_value[15:8], 8'h00);
    wide = 1; bad = 0;
    for (int i = 0; i < 300; i++) begin
      if (cmp_match !== 1'b0) bad++;
      ticks(1);
    end
    check("R9 wide mode compare off", bad, 0);
    check("R9 wide high byte shows shared reg", cap_value[15:8], 8'h37);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule